// File: doc/BRIEF.md
# Byte-Stepped Two-Wire Master Transmitter

This block is a two-wire bus master that a host processor steps one byte at a time. The host writes a control byte, a data byte and a half-period count through a small register port. After each bus event the block posts a status code and raises an interrupt flag, and then it waits. The host reads the status code and chooses the next action: load another byte, or request a stop. Clearing the interrupt flag is the only thing that moves the bus forward.

The bus pins are modelled as open-drain drivers. Each pin has an active-low output enable, where 0 pulls the wire low and 1 releases it. The data wire also has a sampled input, which the block reads for the acknowledge bit. The block runs only as a master transmitter: it sends the start condition, the address-with-write byte, the data bytes and the stop condition.

The state machine has these states. IDLE has both wires released. START_A pulls SDA low while SCL stays high. START_B then pulls SCL low. HOLD keeps SCL low while the interrupt flag is set. BIT_LO and BIT_HI form the low and high halves of each data bit. ACK_LO and ACK_HI form the ninth clock, during which SDA is released. STOP_A, STOP_B and STOP_C pull SDA low, release SCL, and then release SDA.

The transitions are:
- IDLE→START_A when enabled, not busy and the start bit is set.
- START_A→START_B→HOLD as each half-period ends. The flag and status 0x08 are set on the second of these.
- HOLD→BIT_LO when the flag is cleared with the stop bit at 0.
- HOLD→STOP_A when the flag is cleared with the stop bit at 1.
- BIT_LO→BIT_HI, then BIT_HI→BIT_LO, eight times in all.
- BIT_HI→ACK_LO after the eighth bit.
- ACK_LO→ACK_HI, then ACK_HI→HOLD. The flag and the acknowledge status are set on the move to HOLD.
- STOP_A→STOP_B→STOP_C→IDLE.

Top module: `smb_byte_master`

## Requirements
- R1: After reset, the control register reads 0x00, the status reads 0xF8 (idle), `irq` is 0 and both output enables read 1 (released).
- R2: The register select values are: 0 for control, 1 for data, 2 for half-period and 3 for status. Status is read-only, and a write to it is ignored. The control bits are: 7 busy (read-only), 6 enable, 4 stop request, 3 interrupt flag and 1 start request. All other control bits read 0. Writing 0 to bit 3 clears the flag; writing 1 to it has no effect. `irq` always equals bit 3.
- R3: With enable at 1, busy at 0 and start request at 1, the block drives SDA low while SCL is high. It then sets busy, sets the flag and loads status 0x08. With enable at 0, no start takes place.
- R4: While busy is 1, a write cannot set the start-request bit, although it can clear it.
- R5: While the flag is 1, SCL is held low and no bit is shifted.
- R6: Clearing the flag with the stop-request bit at 0 sends the data register most significant bit first on eight SCL pulses. SDA is then released for a ninth pulse, at whose end SDA is sampled as the acknowledge (0 means acknowledged).
- R7: For the byte sent right after status 0x08, the block sets the flag and loads 0x18 if the byte was acknowledged, or 0x20 if it was not.
- R8: For any other byte, the block sets the flag and loads 0x28 if the byte was acknowledged, or 0x30 if it was not.
- R9: A control write that clears the flag with the stop-request bit at 1 generates a stop and sends no byte, even if the data register holds a byte. The stop is SDA rising while SCL is high. Afterwards, busy and stop request read 0, the status reads 0xF8 and the flag stays 0.
- R10: Outside the start and stop conditions, SDA does not change while SCL is high.
- R11: Every SCL low phase and high phase lasts N system-clock cycles, where N is the half-period register value. A value of 0 acts as 1. The value after reset is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 half-period, 3 status |
| reg_wdata | input | 8 | Write data |
| ctl_rd | output | 8 | Control register readback |
| stat_rd | output | 8 | Status code |
| irq | output | 1 | Interrupt flag |
| scl_oe_n | output | 1 | SCL pull-down enable, active low |
| sda_oe_n | output | 1 | SDA pull-down enable, active low |
| sda_in | input | 1 | Sampled SDA wire level |

## Verification
Clearing the interrupt flag and requesting a stop can land in the same host write. The block then has to choose between shifting out the data byte it holds and ending the transfer. The bench provokes this by loading a data byte and then writing a control value that clears the flag and sets the stop request together. The result is judged at the wires: a slave model counts the bytes it receives and the stop conditions it sees, so the expected outcome is one new stop and no new byte. A second collision is a start-request write that arrives mid-transfer. It is judged by reading back the control register, and by checking that no extra start appears on the wires after the stop.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START_A, S_START_B, S_HOLD,
        S_BIT_LO, S_BIT_HI, S_ACK_LO, S_ACK_HI,
        S_STOP_A, S_STOP_B, S_STOP_C
    } smb_state_e;

    localparam logic [7:0] ST_IDLE     = 8'hF8;
    localparam logic [7:0] ST_START    = 8'h08;
    localparam logic [7:0] ST_ADR_ACK  = 8'h18;
    localparam logic [7:0] ST_ADR_NACK = 8'h20;
    localparam logic [7:0] ST_DAT_ACK  = 8'h28;
    localparam logic [7:0] ST_DAT_NACK = 8'h30;

    localparam logic [1:0] SEL_CTL  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_HALF = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int B_BUSY = 7;
    localparam int B_ENA  = 6;
    localparam int B_STO  = 4;
    localparam int B_SI   = 3;
    localparam int B_STA  = 1;

endpackage

// File: rtl/smb_half_timer.sv
module smb_half_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] div,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    assign lim_m1 = (div == '0) ? '0 : div - CW'(1);
    assign done   = (cnt_q >= lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (!done)   cnt_q <= cnt_q + CW'(1);
    end

    // R11: the count restarts at every phase change, so it cannot pass the limit of a steady divider
    p_cnt_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart) == 1'b0 && $stable(div) && $past(done)) |-> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/smb_tx_shift.sv
module smb_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;

    assign msb  = sh_q[W-1];
    assign last = (cnt_q == CNT_W'(W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R6: no shift is requested past the final bit
    p_no_overshift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master
    import smb_pkg::*;
#(
    parameter int          REG_W    = 8,
    parameter logic [7:0]  HALF_RST = 8'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] ctl_rd,
    output logic [REG_W-1:0] stat_rd,
    output logic             irq,
    output logic             scl_oe_n,
    output logic             sda_oe_n,
    input  logic             sda_in
);
    smb_state_e state_q, state_d;

    logic             ena_q, sta_q, sto_q, si_q, busy_q, adr_q;
    logic [REG_W-1:0] data_q, half_q, status_q;
    logic             ph_done, bit_msb, bit_last;
    logic             wr_ctl, si_clr;
    logic             ev_begin, ev_start_done, ev_ack_done, ev_stop_done;

    assign wr_ctl = reg_wr && (reg_sel == SEL_CTL);
    assign si_clr = wr_ctl && si_q && !reg_wdata[B_SI];

    assign ev_begin      = (state_q == S_IDLE)    && (state_d == S_START_A);
    assign ev_start_done = (state_q == S_START_B) && ph_done;
    assign ev_ack_done   = (state_q == S_ACK_HI)  && ph_done;
    assign ev_stop_done  = (state_q == S_STOP_C)  && ph_done;

    smb_half_timer #(.CW(REG_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .div     (half_q),
        .done    (ph_done)
    );

    smb_tx_shift #(.W(REG_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  ((state_q == S_HOLD) && (state_d == S_BIT_LO)),
        .din   (data_q),
        .shift ((state_q == S_BIT_HI) && ph_done && !bit_last),
        .msb   (bit_msb),
        .last  (bit_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (ena_q && sta_q && !busy_q) state_d = S_START_A;
            S_START_A: if (ph_done) state_d = S_START_B;
            S_START_B: if (ph_done) state_d = S_HOLD;
            S_HOLD:    if (si_clr)  state_d = reg_wdata[B_STO] ? S_STOP_A : S_BIT_LO;
            S_BIT_LO:  if (ph_done) state_d = S_BIT_HI;
            S_BIT_HI:  if (ph_done) state_d = bit_last ? S_ACK_LO : S_BIT_LO;
            S_ACK_LO:  if (ph_done) state_d = S_ACK_HI;
            S_ACK_HI:  if (ph_done) state_d = S_HOLD;
            S_STOP_A:  if (ph_done) state_d = S_STOP_B;
            S_STOP_B:  if (ph_done) state_d = S_STOP_C;
            S_STOP_C:  if (ph_done) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Wire outputs (1 = released, 0 = pulled low)
    always_comb begin
        scl_oe_n = 1'b1;
        sda_oe_n = 1'b1;
        unique case (state_q)
            S_IDLE:    begin scl_oe_n = 1'b1; sda_oe_n = 1'b1;    end
            S_START_A: begin scl_oe_n = 1'b1; sda_oe_n = 1'b0;    end
            S_START_B: begin scl_oe_n = 1'b0; sda_oe_n = 1'b0;    end
            S_HOLD:    begin scl_oe_n = 1'b0; sda_oe_n = 1'b1;    end
            S_BIT_LO:  begin scl_oe_n = 1'b0; sda_oe_n = bit_msb; end
            S_BIT_HI:  begin scl_oe_n = 1'b1; sda_oe_n = bit_msb; end
            S_ACK_LO:  begin scl_oe_n = 1'b0; sda_oe_n = 1'b1;    end
            S_ACK_HI:  begin scl_oe_n = 1'b1; sda_oe_n = 1'b1;    end
            S_STOP_A:  begin scl_oe_n = 1'b0; sda_oe_n = 1'b0;    end
            S_STOP_B:  begin scl_oe_n = 1'b1; sda_oe_n = 1'b0;    end
            S_STOP_C:  begin scl_oe_n = 1'b1; sda_oe_n = 1'b1;    end
            default:   begin scl_oe_n = 1'b1; sda_oe_n = 1'b1;    end
        endcase
    end

    // Host registers; bus events are applied after host writes and take precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q    <= 1'b0;
            sta_q    <= 1'b0;
            sto_q    <= 1'b0;
            si_q     <= 1'b0;
            busy_q   <= 1'b0;
            adr_q    <= 1'b0;
            data_q   <= '0;
            half_q   <= HALF_RST;
            status_q <= ST_IDLE;
        end else begin
            if (wr_ctl) begin
                ena_q <= reg_wdata[B_ENA];
                sto_q <= reg_wdata[B_STO];
                sta_q <= busy_q ? (sta_q & reg_wdata[B_STA]) : reg_wdata[B_STA];
                if (si_clr) si_q <= 1'b0;
            end
            if (reg_wr && reg_sel == SEL_DATA) data_q <= reg_wdata;
            if (reg_wr && reg_sel == SEL_HALF) half_q <= reg_wdata;
            if (ev_begin) busy_q <= 1'b1;
            if (ev_start_done) begin
                si_q     <= 1'b1;
                status_q <= ST_START;
                adr_q    <= 1'b1;
            end
            if (ev_ack_done) begin
                si_q     <= 1'b1;
                adr_q    <= 1'b0;
                if (adr_q) status_q <= sda_in ? ST_ADR_NACK : ST_ADR_ACK;
                else       status_q <= sda_in ? ST_DAT_NACK : ST_DAT_ACK;
            end
            if (ev_stop_done) begin
                busy_q   <= 1'b0;
                sto_q    <= 1'b0;
                status_q <= ST_IDLE;
            end
        end
    end

    assign ctl_rd  = {busy_q, ena_q, 1'b0, sto_q, si_q, 1'b0, sta_q, 1'b0};
    assign stat_rd = status_q;
    assign irq     = si_q;

    // R10: SDA stays put across a high SCL except when framing a start or stop
    p_sda_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe_n && $past(scl_oe_n) && state_q != S_START_A && state_q != S_STOP_C)
        |-> $stable(sda_oe_n));

    // R5: a pending flag holds the clock low
    p_hold_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        si_q |-> !scl_oe_n);

    // R3: the flag is only ever raised inside a busy transfer
    p_si_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        si_q |-> busy_q);

    // R4: a busy bus never sees the start request go from 0 to 1
    p_sta_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> !$rose(sta_q));

    // R7, R8: each raise of the flag carries a defined code
    p_status_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_q) |-> (status_q == ST_START || status_q == ST_ADR_ACK ||
                         status_q == ST_ADR_NACK || status_q == ST_DAT_ACK ||
                         status_q == ST_DAT_NACK));

    // R9: leaving busy leaves stop request clear and status idle
    p_stop_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (!sto_q && !si_q && status_q == ST_IDLE));
endmodule

// File: tb/smb_byte_master_bench.sv
module smb_byte_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] ctl_rd, stat_rd;
    logic       irq, scl_oe_n, sda_oe_n;
    logic       slave_pull = 1'b0;
    logic       ack_cfg = 1'b1;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    assign sda_line = sda_oe_n & ~slave_pull;

    always #2.5 clk = ~clk;

    smb_byte_master u_smb_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rd(ctl_rd), .stat_rd(stat_rd), .irq(irq),
        .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .sda_in(sda_line)
    );

    // Slave model: decodes wire activity, acknowledges per ack_cfg
    logic       pscl = 1'b1, psda = 1'b1;
    logic [7:0] sh = 8'd0;
    logic [7:0] rx [0:15];
    int bits = 0, rxn = 0, starts = 0, stops = 0, hi_run = 0, hi_last = 0;
    logic ackph = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe_n && pscl && psda && !sda_line) begin
                starts++; bits = 0; sh = 8'd0; ackph = 1'b0;
            end else if (scl_oe_n && pscl && !psda && sda_line) begin
                stops++;
            end else if (scl_oe_n && !pscl) begin
                if (bits < 8) begin sh = {sh[6:0], sda_line}; bits++; end
                else if (bits == 8) bits = 9;
            end else if (!scl_oe_n && pscl) begin
                if (bits == 8 && !ackph) begin
                    slave_pull = ack_cfg; ackph = 1'b1;
                    rx[rxn % 16] = sh; rxn++;
                end else if (ackph && bits == 9) begin
                    slave_pull = 1'b0; ackph = 1'b0; bits = 0;
                end
            end
            if (scl_oe_n) hi_run = pscl ? hi_run + 1 : 1;
            else if (pscl) hi_last = hi_run;
            pscl = scl_oe_n;
            psda = sda_line;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk(irq == 1'b1, tag, irq, 1);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (ctl_rd[7] && n < 5000) begin @(negedge clk); n++; end
        chk(ctl_rd[7] == 1'b0, tag, ctl_rd[7], 0);
    endtask

    task automatic t_reset;
        chk(ctl_rd == 8'h00, "R1 control", ctl_rd, 8'h00);
        chk(stat_rd == 8'hF8, "R1 status", stat_rd, 8'hF8);
        chk({irq, scl_oe_n, sda_oe_n} == 3'b011, "R1 wires", {irq, scl_oe_n, sda_oe_n}, 3'b011);
    endtask

    task automatic t_regs;
        wr(2'd0, 8'h48);
        chk(ctl_rd == 8'h40, "R2 enable readback, SI write-one ignored", ctl_rd, 8'h40);
        chk(irq == 1'b0, "R2 irq follows SI", irq, 0);
        wr(2'd3, 8'h00);
        chk(stat_rd == 8'hF8, "R2 status write ignored", stat_rd, 8'hF8);
    endtask

    task automatic t_disabled_start;
        wr(2'd0, 8'h02);
        repeat (60) @(negedge clk);
        chk(starts == 0 && ctl_rd[7] == 1'b0, "R3 no start when disabled", starts, 0);
        wr(2'd0, 8'h40);
    endtask

    task automatic t_start_and_hold;
        wr(2'd0, 8'h42);
        wait_irq("R3 flag after start");
        chk(stat_rd == 8'h08, "R3 start status", stat_rd, 8'h08);
        chk(ctl_rd[7] == 1'b1 && starts == 1, "R3 busy and start seen", {ctl_rd[7], 8'(starts)}, 9'h101);
        repeat (50) @(negedge clk);
        chk(scl_oe_n == 1'b0 && irq && rxn == 0, "R5 hold while flag set", {scl_oe_n, 8'(rxn)}, 0);
    endtask

    task automatic t_address_ack;
        ack_cfg = 1'b1;
        wr(2'd1, 8'h94);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h42);
        chk(ctl_rd[1] == 1'b0, "R4 start request blocked while busy", ctl_rd[1], 0);
        wait_irq("R7 flag after address");
        chk(stat_rd == 8'h18, "R7 address ack status", stat_rd, 8'h18);
        chk(rxn == 1 && rx[0] == 8'h94, "R6 address bits msb first", rx[0], 8'h94);
    endtask

    task automatic t_data_ack;
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'h40);
        wait_irq("R8 flag after data");
        chk(stat_rd == 8'h28, "R8 data ack status", stat_rd, 8'h28);
        chk(rxn == 2 && rx[1] == 8'hA5, "R6 data bits msb first", rx[1], 8'hA5);
    endtask

    task automatic t_data_nack_slow;
        ack_cfg = 1'b0;
        wr(2'd2, 8'd7);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h40);
        wait_irq("R8 flag after nack");
        chk(stat_rd == 8'h30, "R8 data nack status", stat_rd, 8'h30);
        chk(rx[2] == 8'h5A, "R6 third byte", rx[2], 8'h5A);
        chk(hi_last == 7, "R11 high phase of 7", hi_last, 7);
        ack_cfg = 1'b1;
    endtask

    task automatic t_stop(input string tag, input int exp_rxn, input int exp_stops);
        wr(2'd0, 8'h50);
        wait_idle({tag, " busy clears"});
        chk(stops == exp_stops, {tag, " stop seen"}, stops, exp_stops);
        chk(rxn == exp_rxn, {tag, " no byte sent"}, rxn, exp_rxn);
        chk(ctl_rd == 8'h40 && stat_rd == 8'hF8 && !irq, {tag, " registers after stop"},
            {ctl_rd, stat_rd}, 16'h40F8);
    endtask

    task automatic t_address_nack_fast;
        wr(2'd2, 8'd0);
        wr(2'd0, 8'h42);
        wait_irq("R3 second start");
        wr(2'd1, 8'h90);
        ack_cfg = 1'b0;
        wr(2'd0, 8'h40);
        wait_irq("R7 flag after address nack");
        chk(stat_rd == 8'h20, "R7 address nack status", stat_rd, 8'h20);
        chk(hi_last == 1, "R11 zero acts as one", hi_last, 1);
        ack_cfg = 1'b1;
    endtask

    task automatic t_stop_wins;
        wr(2'd1, 8'h11);
        t_stop("R9 stop and flag clear together", 4, 2);
        repeat (40) @(negedge clk);
        chk(starts == 2, "R4 R10 no stray start or stop", starts, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled_start();
        t_start_and_hold();
        t_address_ack();
        t_data_ack();
        t_data_nack_slow();
        t_stop("R9 stop after data", 3, 1);
        t_address_nack_fast();
        t_stop_wins();
        chk(stops == 2, "R10 stop count", stops, 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule